// File: doc/BRIEF.md
# GPIO Port with Alternate-Function Mux

This block is one general-purpose I/O port of up to sixteen pins. Each pin can be an input, an output driven from a register, or a pass-through for one on-chip peripheral signal. A small register bus reaches three registers in a 16-byte window: per-pin mode, pin data and pull-up control. The block drives each pad's output value, output enable and pull-up enable. It returns pad levels through a two-flop synchronizer, both on data reads and to the attached peripherals.

The wide flavour gives every pin a two-bit mode field. A parameter selects a narrow flavour instead, with one mode bit per pin. In the narrow flavour a pin can only be a driven output or a peripheral pass-through, and pass-through is its reset state. The register interface is single-cycle. Writes take effect at the clock edge. Reads are combinational from the current offset.

Top module: `gpio_altfn_port`

## Requirements
- R1: In the wide flavour, pin n is controlled by mode-register bits [2n+1:2n]. Code 00 selects input, 01 output, 10 peripheral pass-through and 11 is reserved.
- R2: A pin in input or reserved mode has pad_oe low and pad_out low.
- R3: A pin in output mode has pad_oe high and pad_out equal to its data-register bit, from the edge that writes that bit onward.
- R4: A pin in pass-through mode copies periph_out and periph_oe onto pad_out and pad_oe. periph_in always carries the synchronized pad level.
- R5: pad_pu_en for pin n is the inverse of pull-up register bit n, so writing 1 disables the pull-up.
- R6: Byte offset 0x0 (bus_addr[3:2]=0) holds the mode register, 0x4 the data register and 0x8 the pull-up register. The mode and pull-up registers read back as written, with unused upper bits zero.
- R7: A data-register read returns the stored bit for output-mode pins. For every other pin it returns the pad level captured two clock edges earlier.
- R8: Writes to the data register are stored whatever the pin mode, and appear on the pad when the pin is later switched to output.
- R9: Synchronous reset sets every wide-flavour mode field to input, clears the data register and clears the pull-up register, so all pull-ups are on.
- R10: Writes to offset 0xC change no register, and reads of 0xC return zero.
- R11: With NARROW=1 each pin has one mode bit, where 0 selects output and 1 selects pass-through. Reset sets every bit to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the port window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pu_en | output | NUM_PINS | Pad pull-up enables |
| periph_out | input | NUM_PINS | Peripheral output value per pin |
| periph_oe | input | NUM_PINS | Peripheral output enable per pin |
| periph_in | output | NUM_PINS | Synchronized pad levels to peripherals |

## Verification
The data-read path is the hardest case to reach from the ports. The same register offset returns stored bits for some pins and delayed pad levels for others. The two sources are only told apart when the pad pattern, the data-register contents and the mode fields all disagree. The stimulus therefore includes a vector that mixes all four modes across neighbouring pins, with deliberately conflicting pad and data bits. A separate directed step changes the pads and samples the read one edge later and again two edges later, which pins down the synchronizer depth.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;

    typedef enum logic [1:0] {
        PM_INPUT   = 2'b00,
        PM_OUTPUT  = 2'b01,
        PM_SPECIAL = 2'b10,
        PM_RSVD    = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        RS_MODE = 2'd0,
        RS_DATA = 2'd1,
        RS_PULL = 2'd2,
        RS_NONE = 2'd3
    } reg_sel_e;

    localparam int OFF_W = 4;

    typedef struct packed {
        logic val;
        logic en;
    } pad_drive_t;

    function automatic reg_sel_e decode_sel(input logic [OFF_W-1:0] off);
        return reg_sel_e'(off[3:2]);
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_altfn_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int NARROW   = 0,
    parameter int DW       = 32,
    localparam int CFG_W   = (NARROW != 0) ? NUM_PINS : 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  reg_sel_e            sel,
    input  logic [DW-1:0]       wdata,
    output logic [CFG_W-1:0]    cfg_q,
    output logic [NUM_PINS-1:0] dat_q,
    output logic [NUM_PINS-1:0] pul_q
);
    localparam logic [CFG_W-1:0] CFG_RST = (NARROW != 0) ? {CFG_W{1'b1}} : {CFG_W{1'b0}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
            dat_q <= '0;
            pul_q <= '0;
        end else if (we) begin
            case (sel)
                RS_MODE: cfg_q <= wdata[CFG_W-1:0];
                RS_DATA: dat_q <= wdata[NUM_PINS-1:0];
                RS_PULL: pul_q <= wdata[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    // R10
    rsvd_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_NONE) |=> ($stable(cfg_q) && $stable(dat_q) && $stable(pul_q)));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (cfg_q == CFG_RST && dat_q == '0 && pul_q == '0));

endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] sync_q
);
    logic [NUM_PINS-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            sync_q <= '0;
        end else begin
            stage1 <= pad_in;
            sync_q <= stage1;
        end
    end

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // R7
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (sync_q == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_altfn_pkg::*;
(
    input  pin_mode_e  mode,
    input  logic       dat_bit,
    input  logic       per_val,
    input  logic       per_en,
    output pad_drive_t drv,
    output logic       from_reg
);
    always_comb begin
        drv      = '{val: 1'b0, en: 1'b0};
        from_reg = 1'b0;
        unique case (mode)
            PM_OUTPUT: begin
                drv      = '{val: dat_bit, en: 1'b1};
                from_reg = 1'b1;
            end
            PM_SPECIAL: drv = '{val: per_val, en: per_en};
            default:    drv = '{val: 1'b0, en: 1'b0};
        endcase
    end
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
    import gpio_altfn_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int NARROW   = 0,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OFF_W-1:0]    bus_addr,
    input  logic                bus_we,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu_en,
    input  logic [NUM_PINS-1:0] periph_out,
    input  logic [NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0] periph_in
);
    localparam int CFG_W = (NARROW != 0) ? NUM_PINS : 2 * NUM_PINS;

    reg_sel_e            sel;
    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] dat_q;
    logic [NUM_PINS-1:0] pul_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] out_mask;
    logic [NUM_PINS-1:0] rd_bits;

    assign sel = decode_sel(bus_addr);

    gpio_port_regs #(.NUM_PINS(NUM_PINS), .NARROW(NARROW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
        .cfg_q(cfg_q), .dat_q(dat_q), .pul_q(pul_q)
    );

    gpio_pad_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .sync_q(sync_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_mode_e  mode;
        pad_drive_t drv;
        if (NARROW != 0) begin : g_narrow
            assign mode = cfg_q[i] ? PM_SPECIAL : PM_OUTPUT;
        end else begin : g_wide
            assign mode = pin_mode_e'(cfg_q[2*i+1:2*i]);
        end
        gpio_pin_mux u_mux (
            .mode(mode), .dat_bit(dat_q[i]), .per_val(periph_out[i]),
            .per_en(periph_oe[i]), .drv(drv), .from_reg(out_mask[i])
        );
        assign pad_out[i] = drv.val;
        assign pad_oe[i]  = drv.en;
        assign rd_bits[i] = out_mask[i] ? dat_q[i] : sync_q[i];
    end

    assign pad_pu_en = ~pul_q;
    assign periph_in = sync_q;

    always_comb begin
        case (sel)
            RS_MODE: bus_rdata = DW'(cfg_q);
            RS_DATA: bus_rdata = DW'(rd_bits);
            RS_PULL: bus_rdata = DW'(pul_q);
            default: bus_rdata = '0;
        endcase
    end

    // R3
    out_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == RS_DATA) |=> (((pad_out ^ $past(bus_wdata[NUM_PINS-1:0])) & out_mask) == '0));

    // R5
    pull_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == RS_PULL) |-> (bus_rdata[NUM_PINS-1:0] == ~pad_pu_en));

    // R2
    idle_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == RS_DATA && !bus_we) |-> ((pad_oe & ~out_mask & ~periph_oe) == '0));

endmodule

// File: tb/gpio_altfn_port_tb.sv
module gpio_altfn_port_tb;
    localparam int N  = 16;
    localparam int NN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] pad = '0, po = '0, poe = '0;
    logic [N-1:0] pout, poen, puen, pin_s;

    gpio_altfn_port #(.NUM_PINS(N), .NARROW(0)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pad_in(pad), .pad_out(pout), .pad_oe(poen),
        .pad_pu_en(puen), .periph_out(po), .periph_oe(poe), .periph_in(pin_s)
    );

    logic [3:0]  n_addr = '0;
    logic        n_we = 1'b0;
    logic [31:0] n_wdata = '0;
    logic [31:0] n_rdata;
    logic [NN-1:0] n_pad = '0, n_po = '0, n_poe = '0;
    logic [NN-1:0] n_pout, n_poen, n_puen, n_pin;

    gpio_altfn_port #(.NUM_PINS(NN), .NARROW(1)) u_dut_narrow (
        .clk(clk), .rst(rst), .bus_addr(n_addr), .bus_we(n_we), .bus_wdata(n_wdata),
        .bus_rdata(n_rdata), .pad_in(n_pad), .pad_out(n_pout), .pad_oe(n_poen),
        .pad_pu_en(n_puen), .periph_out(n_po), .periph_oe(n_poe), .periph_in(n_pin)
    );

    typedef struct packed {
        logic [31:0] cfg;
        logic [15:0] dat, pu, pad, po, poe, eout, eoe, epu, erd;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h5555_5555, 16'hA5A5, 16'h0000, 16'h1234, 16'hFFFF, 16'h0000, 16'hA5A5, 16'hFFFF, 16'hFFFF, 16'hA5A5},
        '{32'h0000_0000, 16'hA5A5, 16'hFFFF, 16'h1234, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h1234},
        '{32'hAAAA_AAAA, 16'h0000, 16'h00FF, 16'hBEEF, 16'h0F0F, 16'h00FF, 16'h0F0F, 16'h00FF, 16'hFF00, 16'hBEEF},
        '{32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, 16'h5A5A, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h5A5A},
        '{32'h0000_00C9, 16'h000F, 16'h1234, 16'h000A, 16'hFFFF, 16'hFFFF, 16'h0003, 16'h0003, 16'hEDCB, 16'h000B}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr_n(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        n_addr = a; n_we = 1'b1; n_wdata = d;
        @(negedge clk);
        n_we = 1'b0;
    endtask

    task automatic rd_n(input logic [3:0] a, output logic [31:0] d);
        n_addr = a;
        #1;
        d = n_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        n_po = 8'hC3; n_poe = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state of the wide port
        rd(4'h0, r); check("R9 mode reg", r, 32'h0);
        rd(4'h8, r); check("R9 pull reg", r, 32'h0);
        rd(4'h4, r); check("R9 data read", r, 32'h0);
        check("R9 pull enables", {16'h0, puen}, 32'h0000_FFFF);
        check("R9 oe", {16'h0, poen}, 32'h0);
        // R11 reset state of the narrow port
        rd_n(4'h0, r); check("R11 narrow mode reset", r, 32'h0000_00FF);
        check("R11 narrow out passthru", {24'h0, n_pout}, 32'h0000_00C3);
        check("R11 narrow oe passthru", {24'h0, n_poen}, 32'h0000_00A5);

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 5; v++) begin
            wr(4'h0, VECS[v].cfg);
            wr(4'h4, {16'h0, VECS[v].dat});
            wr(4'h8, {16'h0, VECS[v].pu});
            pad = VECS[v].pad; po = VECS[v].po; poe = VECS[v].poe;
            repeat (2) @(negedge clk);
            check($sformatf("R1/R3/R4 pad_out v%0d", v), {16'h0, pout}, {16'h0, VECS[v].eout});
            check($sformatf("R2/R4 pad_oe v%0d", v), {16'h0, poen}, {16'h0, VECS[v].eoe});
            check($sformatf("R5 pull en v%0d", v), {16'h0, puen}, {16'h0, VECS[v].epu});
            check($sformatf("R4 periph_in v%0d", v), {16'h0, pin_s}, {16'h0, VECS[v].pad});
            rd(4'h4, r); check($sformatf("R7 data read v%0d", v), r, {16'h0, VECS[v].erd});
            rd(4'h0, r); check($sformatf("R6 mode readback v%0d", v), r, VECS[v].cfg);
            rd(4'h8, r); check($sformatf("R6 pull readback v%0d", v), r, {16'h0, VECS[v].pu});
        end

        // R7 synchronizer depth
        wr(4'h0, 32'h0);
        pad = 16'h0000;
        repeat (3) @(negedge clk);
        pad = 16'hFFFF;
        @(negedge clk);
        rd(4'h4, r); check("R7 one edge old level", r, 32'h0);
        @(negedge clk);
        rd(4'h4, r); check("R7 two edges new level", r, 32'h0000_FFFF);

        // R8 data stored while input, shown on switch to output
        wr(4'h4, 32'h0000_1357);
        check("R8 still undriven", {16'h0, poen}, 32'h0);
        wr(4'h0, 32'h5555_5555);
        check("R8 stored data driven", {16'h0, pout}, 32'h0000_1357);
        wr(4'h8, 32'h0000_0F0F);

        // R10 reserved offset
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, r); check("R10 reserved read", r, 32'h0);
        rd(4'h0, r); check("R10 mode untouched", r, 32'h5555_5555);
        rd(4'h4, r); check("R10 data untouched", r, 32'h0000_1357);
        rd(4'h8, r); check("R10 pull untouched", r, 32'h0000_0F0F);
        check("R10 pads untouched", {16'h0, pout}, 32'h0000_1357);

        // R11 narrow flavour modes
        wr_n(4'h4, 32'h0000_003C);
        wr_n(4'h0, 32'h0000_0000);
        check("R11 narrow output value", {24'h0, n_pout}, 32'h0000_003C);
        check("R11 narrow output enable", {24'h0, n_poen}, 32'h0000_00FF);
        n_pad = 8'h96;
        wr_n(4'h0, 32'h0000_00F0);
        @(negedge clk);
        check("R11 narrow mixed out", {24'h0, n_pout}, 32'h0000_00CC);
        check("R11 narrow mixed oe", {24'h0, n_poen}, 32'h0000_00AF);
        rd_n(4'h4, r); check("R11 narrow mixed read", r, 32'h0000_009C);

        // R9 reset after use
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(4'h0, r); check("R9 mode after rerun reset", r, 32'h0);
        rd(4'h8, r); check("R9 pull after rerun reset", r, 32'h0);
        wr(4'h0, 32'h5555_5555);
        check("R9 data cleared", {16'h0, pout}, 32'h0);
        rd_n(4'h0, r); check("R11 narrow mode after reset", r, 32'h0000_00FF);

        finish_run();
    end
endmodule